// File: doc/BRIEF.md
# Device Error Signaling Gate

This block sits beside a single PCIe function and decides what happens when that function detects an error. It receives one error event at a time: a one-hot error code, a flag that says whether the code belongs to the correctable or the uncorrectable class, and a flag that says whether a non-fatal uncorrectable error may be treated as advisory. It also sees the function's correctable mask, uncorrectable mask and severity registers, the four reporting enables of the device control register, and the system-error enable of the command register.

For each accepted event it produces, one cycle later, a single-cycle set of results. These are set-pulses for the device status bits and for the correctable and uncorrectable error status registers, a request to the header logger, and at most one outgoing error message with its severity. The register files that hold the status bits, the header logger and the forwarding of messages through bridges are separate blocks that consume these pulses.

A build parameter selects whether the function has a severity register. Without one, the fatal or non-fatal class of each uncorrectable error comes from a fixed built-in table.

Top module: `err_signal_gate`

## Requirements
- R1: The incoming code is first ANDed with the supported mask of its class. Uncorrectable supported bits are 4, 5 and 12 to 25. Correctable supported bits are 0, 6, 7, 8 and 12 to 15. If the result does not have exactly one bit set, the event is rejected: `reject` pulses and every other output stays zero.
- R2: With the severity register present (`HAS_SEV_REG`=1), an uncorrectable error is fatal exactly when its bit is set in `unc_sev`.
- R3: With `HAS_SEV_REG`=0, `unc_sev` is ignored. Uncorrectable bits 4, 5, 13, 17, 18 and 22 are fatal and all other supported bits are non-fatal.
- R4: A correctable error pulses device status bit 0 (correctable detected) and sets its own bit in `corr_sta_set`. If that bit is set in `corr_mask`, no message is sent.
- R5: An unmasked correctable error sends a message only when `en_corr` is set. The message severity is encoded 0 for correctable, 1 for non-fatal and 2 for fatal. `msg_sev` reads 0 whenever `msg_valid` is low.
- R6: A fatal or non-fatal uncorrectable error that is not rerouted pulses device status bit 2 or bit 1 respectively. It also pulses bit 3 when the code is unsupported request (bit 20), and sets its bit in `unc_sta_set`. If the error is masked in `unc_mask`, nothing more happens. If it is unmasked, `log_req` pulses.
- R7: An unmasked uncorrectable unsupported request with both `en_ur` and `serr_en` clear sends no message. Otherwise a fatal error sends severity 2 when `serr_en` or `en_fatal` is set, and a non-fatal error sends severity 1 when `serr_en` or `en_nonfatal` is set.
- R8: A non-fatal uncorrectable error with `err_adv_ok` set takes the correctable path as correctable bit 13. It pulses device status bit 0, plus bit 3 for an unsupported request. If bit 13 is masked in `corr_mask`, it stops there. Otherwise its uncorrectable bit is set in `unc_sta_set` whatever `unc_mask` holds. `log_req` pulses only if that bit is unmasked. The message follows R5 and additionally needs `en_ur` for an unsupported request.
- R9: `in_ready` is high from the first cycle after reset. The results of an event accepted at a clock edge appear after that edge and last exactly one cycle. Cycles without an accepted event produce all-zero outputs.
- R10: During and directly after reset every output, including `in_ready`, is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Error event offered |
| in_ready | output | 1 | Event can be taken this cycle |
| err_code | input | 32 | Error status bit of the event |
| err_is_corr | input | 1 | Event belongs to the correctable class |
| err_adv_ok | input | 1 | Event may be handled as advisory non-fatal |
| corr_mask | input | 32 | Correctable error mask register |
| unc_mask | input | 32 | Uncorrectable error mask register |
| unc_sev | input | 32 | Uncorrectable severity register |
| en_corr | input | 1 | Correctable reporting enable |
| en_nonfatal | input | 1 | Non-fatal reporting enable |
| en_fatal | input | 1 | Fatal reporting enable |
| en_ur | input | 1 | Unsupported-request reporting enable |
| serr_en | input | 1 | Command register system-error enable |
| dsta_set | output | 4 | Device status set pulses: 0 corr, 1 non-fatal, 2 fatal, 3 unsupported request |
| corr_sta_set | output | 32 | Correctable status bits to set |
| unc_sta_set | output | 32 | Uncorrectable status bits to set |
| log_req | output | 1 | Request a header log entry |
| msg_valid | output | 1 | Outgoing error message |
| msg_sev | output | 2 | Message severity |
| reject | output | 1 | Event rejected as not one-hot |

## Verification
The hardest case to reach is the advisory reroute when the masks disagree. A non-fatal unsupported request marked advisory, with bit 13 unmasked in the correctable mask but masked in the uncorrectable mask, must set the uncorrectable status bit without logging. Whether it sends a message then depends on both `en_corr` and `en_ur`. The sweep reaches this by crossing every code bit and both class flags with all 256 combinations of the five enables, the two masks and the severity register. A second instance without a severity register runs alongside, so that every default-table class meets the advisory path as well.

// File: rtl/esg_pkg.sv
// Package: shared constants and types of the device error signaling gate.
// Assumes the standard bit layout of the correctable and uncorrectable
// error status registers, since downstream status registers decode it.
package esg_pkg;

    localparam int ERR_W = 32;
    typedef logic [ERR_W-1:0] err_vec_t;

    // Supported bits of each class
    localparam err_vec_t UNC_SUPPORTED     = 32'h03FF_F030;
    localparam err_vec_t COR_SUPPORTED     = 32'h0000_F1C1;
    // Uncorrectable errors that are fatal when no severity register exists
    localparam err_vec_t UNC_DEFAULT_FATAL = 32'h0046_2030;

    localparam int UNC_UR_BIT       = 20;
    localparam int COR_ADVISORY_BIT = 13;

    // Device status set-pulse positions
    localparam int DSTA_W   = 4;
    localparam int DSTA_CED = 0;
    localparam int DSTA_NFD = 1;
    localparam int DSTA_FED = 2;
    localparam int DSTA_URD = 3;

    typedef enum logic [1:0] {
        SEV_COR      = 2'd0,
        SEV_NONFATAL = 2'd1,
        SEV_FATAL    = 2'd2
    } msg_sev_e;

    typedef struct packed {
        logic [DSTA_W-1:0] dsta;
        err_vec_t          corr_set;
        err_vec_t          unc_set;
        logic              log_req;
        logic              msg_valid;
        msg_sev_e          sev;
        logic              reject;
    } esg_result_t;

    typedef struct packed {
        logic en_corr;
        logic en_nonfatal;
        logic en_fatal;
        logic en_ur;
        logic serr_en;
    } esg_enables_t;

endpackage

// File: rtl/esg_classify.sv
// Module: esg_classify
// Qualifies an incoming error code against the supported mask of its
// class, checks that exactly one bit remains, and classifies an
// uncorrectable error as fatal or non-fatal. HAS_SEV_REG selects the
// severity register or the built-in default table as the source of the
// fatal decision. Purely combinational.
module esg_classify
    import esg_pkg::*;
#(
    parameter bit HAS_SEV_REG = 1'b1
) (
    input  err_vec_t err_code,
    input  logic     is_corr,
    input  err_vec_t unc_sev,
    output err_vec_t code_q,
    output logic     code_ok,
    output logic     is_fatal,
    output logic     is_ur
);

    err_vec_t fatal_src;

    // Mask the code with the supported bits of its class
    always_comb code_q = err_code & (is_corr ? COR_SUPPORTED : UNC_SUPPORTED);

    // Exactly one bit must survive qualification
    always_comb code_ok = (code_q != '0) && ((code_q & (code_q - err_vec_t'(1))) == '0);

    // Pick the source of the fatal/non-fatal decision
    generate
        if (HAS_SEV_REG) begin : g_sev_reg
            always_comb fatal_src = unc_sev;
        end else begin : g_sev_table
            // The severity input is tied into a don't-care path so that it stays used
            always_comb fatal_src = UNC_DEFAULT_FATAL | (unc_sev & '0);
        end
    endgenerate

    // Classify the qualified uncorrectable error
    always_comb begin
        is_fatal = !is_corr && ((code_q & fatal_src) != '0);
        is_ur    = !is_corr && code_q[UNC_UR_BIT];
    end

endmodule

// File: rtl/esg_decide.sv
// Module: esg_decide
// Walks the signaling flowchart for one qualified error: picks the
// correctable, advisory or uncorrectable path, forms the status set
// pulses and the log request, and applies the reporting enables to the
// outgoing message. Purely combinational; assumes inputs from
// esg_classify.
module esg_decide
    import esg_pkg::*;
(
    input  err_vec_t     code_q,
    input  logic         code_ok,
    input  logic         is_corr,
    input  logic         is_fatal,
    input  logic         is_ur,
    input  logic         adv_ok,
    input  err_vec_t     corr_mask,
    input  err_vec_t     unc_mask,
    input  esg_enables_t en,
    output esg_result_t  res
);

    localparam err_vec_t ADV_VEC = err_vec_t'(1) << COR_ADVISORY_BIT;

    logic     take_corr_path;
    logic     advisory;
    err_vec_t corr_bit;
    logic     corr_masked;
    logic     unc_masked;
    logic     ur_blocked_corr;
    logic     ur_blocked_unc;
    logic     unc_allowed;

    // Path selection and the masking terms shared by both paths
    always_comb begin
        advisory        = !is_corr && !is_fatal && adv_ok;
        take_corr_path  = is_corr || advisory;
        corr_bit        = is_corr ? code_q : ADV_VEC;
        corr_masked     = (corr_bit & corr_mask) != '0;
        unc_masked      = (code_q & unc_mask) != '0;
        ur_blocked_corr = is_ur && !en.en_ur;
        ur_blocked_unc  = is_ur && !en.en_ur && !en.serr_en;
        unc_allowed     = en.serr_en || (is_fatal ? en.en_fatal : en.en_nonfatal);
    end

    // Build the result for the selected path
    always_comb begin
        res = '0;
        if (!code_ok) begin
            res.reject = 1'b1;
        end else if (take_corr_path) begin
            res.dsta[DSTA_CED] = 1'b1;
            res.dsta[DSTA_URD] = is_ur;
            res.corr_set       = corr_bit;
            if (!corr_masked) begin
                if (advisory) begin
                    res.unc_set = code_q;
                    res.log_req = !unc_masked;
                end
                if (!ur_blocked_corr && en.en_corr) begin
                    res.msg_valid = 1'b1;
                    res.sev       = SEV_COR;
                end
            end
        end else begin
            res.dsta[DSTA_FED] = is_fatal;
            res.dsta[DSTA_NFD] = !is_fatal;
            res.dsta[DSTA_URD] = is_ur;
            res.unc_set        = code_q;
            if (!unc_masked) begin
                res.log_req = 1'b1;
                if (!ur_blocked_unc && unc_allowed) begin
                    res.msg_valid = 1'b1;
                    res.sev       = is_fatal ? SEV_FATAL : SEV_NONFATAL;
                end
            end
        end
    end

endmodule

// File: rtl/err_signal_gate.sv
// Module: err_signal_gate (top)
// Takes one detected error per cycle through a valid/ready handshake and
// registers the decision of esg_classify/esg_decide as one-cycle pulses.
// Assumes the surrounding register files apply the set pulses and that
// the message consumer takes a message in the cycle it is valid.
module err_signal_gate
    import esg_pkg::*;
#(
    parameter bit HAS_SEV_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [ERR_W-1:0]     err_code,
    input  logic                 err_is_corr,
    input  logic                 err_adv_ok,
    input  logic [ERR_W-1:0]     corr_mask,
    input  logic [ERR_W-1:0]     unc_mask,
    input  logic [ERR_W-1:0]     unc_sev,
    input  logic                 en_corr,
    input  logic                 en_nonfatal,
    input  logic                 en_fatal,
    input  logic                 en_ur,
    input  logic                 serr_en,
    output logic [DSTA_W-1:0]    dsta_set,
    output logic [ERR_W-1:0]     corr_sta_set,
    output logic [ERR_W-1:0]     unc_sta_set,
    output logic                 log_req,
    output logic                 msg_valid,
    output logic [1:0]           msg_sev,
    output logic                 reject
);

    err_vec_t     code_q;
    logic         code_ok;
    logic         is_fatal;
    logic         is_ur;
    esg_enables_t en;
    esg_result_t  res_d;
    esg_result_t  res_q;
    logic         accept;

    // Gather the enables into one bundle
    always_comb en = '{en_corr: en_corr, en_nonfatal: en_nonfatal,
                       en_fatal: en_fatal, en_ur: en_ur, serr_en: serr_en};

    // An event is taken when offered while ready
    always_comb accept = in_valid && in_ready;

    esg_classify #(.HAS_SEV_REG(HAS_SEV_REG)) classify_i (
        .err_code (err_code),
        .is_corr  (err_is_corr),
        .unc_sev  (unc_sev),
        .code_q   (code_q),
        .code_ok  (code_ok),
        .is_fatal (is_fatal),
        .is_ur    (is_ur)
    );

    esg_decide decide_i (
        .code_q    (code_q),
        .code_ok   (code_ok),
        .is_corr   (err_is_corr),
        .is_fatal  (is_fatal),
        .is_ur     (is_ur),
        .adv_ok    (err_adv_ok),
        .corr_mask (corr_mask),
        .unc_mask  (unc_mask),
        .en        (en),
        .res       (res_d)
    );

    // Ready rises in the first cycle after reset and stays high
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    // Register the decision for exactly one cycle per accepted event
    always_ff @(posedge clk) begin
        if (!rst_n || !accept) res_q <= '0;
        else                   res_q <= res_d;
    end

    // Drive the output ports from the registered result
    always_comb begin
        dsta_set     = res_q.dsta;
        corr_sta_set = res_q.corr_set;
        unc_sta_set  = res_q.unc_set;
        log_req      = res_q.log_req;
        msg_valid    = res_q.msg_valid;
        msg_sev      = res_q.sev;
        reject       = res_q.reject;
    end

    // R9
    pulse_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid || log_req || reject || dsta_set != '0) |-> $past(in_valid && in_ready));

    // R1
    reject_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (dsta_set == '0 && corr_sta_set == '0 && unc_sta_set == '0
                    && !log_req && !msg_valid));

    // R1
    single_status_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(corr_sta_set) && $onehot0(unc_sta_set));

    // R6
    log_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_req |-> (unc_sta_set != '0));

    // R6
    one_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dsta_set[DSTA_FED:DSTA_CED]) <= 1);

    // R5
    sev_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |-> (msg_sev == 2'd0));

endmodule

// File: tb/err_signal_gate_tb_top.sv
module err_signal_gate_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] err_code = '0;
    logic        err_is_corr = 1'b0;
    logic        err_adv_ok = 1'b0;
    logic [31:0] corr_mask = '0;
    logic [31:0] unc_mask = '0;
    logic [31:0] unc_sev = '0;
    logic        en_corr = 1'b0, en_nonfatal = 1'b0, en_fatal = 1'b0, en_ur = 1'b0, serr_en = 1'b0;

    logic        rdy_a, rdy_b;
    logic [3:0]  dsta_a, dsta_b;
    logic [31:0] cset_a, cset_b, uset_a, uset_b;
    logic        log_a, log_b, mv_a, mv_b, rej_a, rej_b;
    logic [1:0]  sev_a, sev_b;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    err_signal_gate #(.HAS_SEV_REG(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a),
        .err_code(err_code), .err_is_corr(err_is_corr), .err_adv_ok(err_adv_ok),
        .corr_mask(corr_mask), .unc_mask(unc_mask), .unc_sev(unc_sev),
        .en_corr(en_corr), .en_nonfatal(en_nonfatal), .en_fatal(en_fatal),
        .en_ur(en_ur), .serr_en(serr_en),
        .dsta_set(dsta_a), .corr_sta_set(cset_a), .unc_sta_set(uset_a),
        .log_req(log_a), .msg_valid(mv_a), .msg_sev(sev_a), .reject(rej_a));

    err_signal_gate #(.HAS_SEV_REG(1'b0)) dut_nosev_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b),
        .err_code(err_code), .err_is_corr(err_is_corr), .err_adv_ok(err_adv_ok),
        .corr_mask(corr_mask), .unc_mask(unc_mask), .unc_sev(unc_sev),
        .en_corr(en_corr), .en_nonfatal(en_nonfatal), .en_fatal(en_fatal),
        .en_ur(en_ur), .serr_en(serr_en),
        .dsta_set(dsta_b), .corr_sta_set(cset_b), .unc_sta_set(uset_b),
        .log_req(log_b), .msg_valid(mv_b), .msg_sev(sev_b), .reject(rej_b));

    // Expected packed result: {dsta, corr, unc, log, msg, sev, reject} = 73 bits
    function automatic logic [72:0] model(input bit has_sev);
        logic [31:0] sup, q, cbit;
        logic [3:0]  ds;
        logic [31:0] cs, us;
        logic        lg, mv, rj, fat, ur, adv;
        logic [1:0]  sv;
        sup = err_is_corr ? 32'h0000_F1C1 : 32'h03FF_F030;
        q = err_code & sup;
        ds = 0; cs = 0; us = 0; lg = 0; mv = 0; sv = 0; rj = 0;
        fat = 0; ur = 0;
        if ($countones(q) != 1) begin
            rj = 1;  // R1
        end else begin
            if (!err_is_corr) begin
                fat = has_sev ? ((q & unc_sev) != 0)          // R2
                              : ((q & 32'h0046_2030) != 0);   // R3
                ur = q[20];
            end
            adv = !err_is_corr && !fat && err_adv_ok;
            if (err_is_corr || adv) begin                     // R4 R8
                cbit = err_is_corr ? q : 32'h0000_2000;
                ds[0] = 1; ds[3] = ur; cs = cbit;
                if ((cbit & corr_mask) == 0) begin
                    if (adv) begin us = q; lg = ((q & unc_mask) == 0); end
                    if (en_corr && !(ur && !en_ur)) begin mv = 1; sv = 2'd0; end  // R5
                end
            end else begin                                    // R6 R7
                if (fat) ds[2] = 1; else ds[1] = 1;
                ds[3] = ur; us = q;
                if ((q & unc_mask) == 0) begin
                    lg = 1;
                    if (!(ur && !en_ur && !serr_en) &&
                        (serr_en || (fat ? en_fatal : en_nonfatal))) begin
                        mv = 1; sv = fat ? 2'd2 : 2'd1;
                    end
                end
            end
        end
        return {ds, cs, us, lg, mv, sv, rj};
    endfunction

    task automatic check(input string tag, input logic [72:0] act, input logic [72:0] exp_v);
        vectors++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s code=%h corr=%0b adv=%0b act=%h exp=%h",
                     tag, err_code, err_is_corr, err_adv_ok, act, exp_v);
        end
    endtask

    function automatic string tag_for(input bit has_sev);
        logic [31:0] q;
        q = err_code & (err_is_corr ? 32'h0000_F1C1 : 32'h03FF_F030);
        if ($countones(q) != 1) return "R1";
        if (err_is_corr) return "R4/R5";
        if (err_adv_ok) return has_sev ? "R2/R8" : "R3/R8";
        return has_sev ? "R2/R6/R7" : "R3/R6/R7";
    endfunction

    // Apply the current inputs for one cycle and check both instances, then an idle cycle
    task automatic apply_and_check();
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        check(tag_for(1'b1), {dsta_a, cset_a, uset_a, log_a, mv_a, sev_a, rej_a}, model(1'b1));
        check(tag_for(1'b0), {dsta_b, cset_b, uset_b, log_b, mv_b, sev_b, rej_b}, model(1'b0));
        in_valid = 1'b0;
        @(negedge clk);
        // R9: results last one cycle, idle gives zeros
        check("R9", {dsta_a, cset_a, uset_a, log_a, mv_a, sev_a, rej_a, dsta_b, cset_b, uset_b,
                     log_b, mv_b, sev_b, rej_b, rdy_a, rdy_b}, {146'd0, 2'b11});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs during reset
        check("R10", {73'd0, rdy_a, dsta_a, cset_a, uset_a, log_a, mv_a, sev_a, rej_a,
                      rdy_b, dsta_b, cset_b, uset_b, log_b, mv_b, sev_b, rej_b}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: ready after reset
        check("R9", {71'd0, rdy_a, rdy_b}, {71'd0, 2'b11});

        // Directed multi-bit and zero codes
        err_is_corr = 1'b0; err_code = 32'h0000_0030; apply_and_check();  // two supported bits
        err_code = 32'h0000_0000; apply_and_check();                       // nothing set
        err_code = 32'h1000_0010; en_fatal = 1'b1; apply_and_check();      // one unsupported + one supported
        err_is_corr = 1'b1; err_code = 32'h0000_3000; apply_and_check();
        err_code = 32'h8000_0001; en_corr = 1'b1; apply_and_check();

        // Sweep: every bit, both classes, advisory flag, all configurations
        for (int c = 0; c < 256; c++) begin
            en_corr     = c[0];
            en_nonfatal = c[1];
            en_fatal    = c[2];
            en_ur       = c[3];
            serr_en     = c[4];
            unc_mask    = c[5] ? 32'hFFFF_FFFF : 32'h0;
            corr_mask   = c[6] ? 32'hFFFF_FFFF : 32'h0;
            unc_sev     = c[7] ? 32'hFFFF_FFFF : 32'h0;
            for (int b = 0; b < 32; b++) begin
                for (int k = 0; k < 4; k++) begin
                    err_code    = 32'h1 << b;
                    err_is_corr = k[0];
                    err_adv_ok  = k[1];
                    apply_and_check();
                end
            end
        end

        // Mixed masks: advisory with only bit 13 of the correctable mask open
        corr_mask = 32'hFFFF_DFFF; unc_mask = 32'h0010_0000; unc_sev = 32'h0;
        en_corr = 1'b1; en_ur = 1'b0; serr_en = 1'b1; err_is_corr = 1'b0; err_adv_ok = 1'b1;
        err_code = 32'h0010_0000; apply_and_check();   // R8 unsupported request blocked by en_ur
        en_ur = 1'b1; apply_and_check();
        err_code = 32'h0000_4000; apply_and_check();   // R8 unmasked, logged
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG_CYCLES) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=%0d exp<%0d", cyc, WATCHDOG_CYCLES);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule